// File: doc/BRIEF.md
# Flash Block Write-Protection Controller

This block holds the write-protection state of every erase block in a NAND-style flash array. Each block is in one of three states: unlocked, locked, or tight. The tight state is a lock that software cannot undo.

A host uses a small synchronous register port. It first writes the target block number into the start-block register. It then strobes one of three commands: lock, unlock or tighten. The addressed block changes state on the clock edge that samples the strobe.

A separate select register picks the block whose state the read-only status register reports, as a one-hot code. A combinational query port tells the array whether program or erase is allowed on a given block. A reset-done interrupt bit is set once after each reset ends. Software clears it by writing, or a command clears it when auto-clear mode is on. When the first block has been turned into one-time-programmable storage, it always reports locked and is never writable.

Top module: `wp_ctrl`

Register map (`reg_addr`):
- 0: start block. Bits [9:0] hold the block number and bits [15:10] read as zero.
- 1: status select. Holds the block number whose state the status register shows.
- 2: status. Read-only.
- 3: interrupt and error. Bit 0 is the reset-done flag and bit 1 is the sticky range-error flag.

Commands (`cmd_op` together with `cmd_valid`): 01 = lock, 10 = unlock, 11 = tighten, 00 = no operation.

## Requirements
- R1: The start-block register (address 0) resets to 0000h and keeps bits [ADDR_W-1:0] of a write. Bits above ADDR_W always read as zero.
- R2: After a reset, commands have no effect on any block until the start-block register has been written at least once.
- R3: Lock moves a block to locked and unlock moves a locked block to unlocked. Status (address 2) is one-hot in bits [2:0], with bit 2 = unlocked, bit 1 = locked and bit 0 = tight, and bits [15:3] read as zero. A command is visible on status in the cycle after its strobe.
- R4: Reset puts every block in the locked state, so status reads 0002h for any in-range selected block.
- R5: A tight block ignores lock and unlock commands, and only a reset returns it to locked.
- R6: A tighten command affects only a locked block. On an unlocked block it has no effect.
- R7: While `otp_first_block` is high, block 0 reads status 0002h and `query_wr_en` is low for block 0.
- R8: `query_wr_en` is high only when `query_blk` is in range and that block is unlocked.
- R9: A command issued while the start-block value is NUM_BLOCKS or larger changes no block and sets the error flag (address 3 bit 1, and `addr_err`). The flag stays set until reset.
- R10: The reset-done flag (address 3 bit 0, and `rst_irq`) goes to 1 one cycle after reset is released. It clears when address 3 is written with bit 0 = 0, or when a command is strobed while `int_auto` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (cold or warm) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for read and write |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational on reg_addr |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 2 | Command opcode |
| int_auto | input | 1 | Auto-clear of the reset-done flag on any command |
| otp_first_block | input | 1 | Block 0 has been made one-time-programmable |
| query_blk | input | 10 | Block asked about by the array |
| query_wr_en | output | 1 | Program or erase allowed on query_blk |
| rst_irq | output | 1 | Reset-done interrupt flag |
| addr_err | output | 1 | Sticky out-of-range command flag |

## Verification
The bench builds the block with NUM_BLOCKS set to 1000 and keeps the 10-bit address. This leaves start-block values from 1000 to 1023 that the register can hold but that name no block, so the out-of-range error path and its effect on the array can be reached. The top in-range block, 999, is used as a boundary case. The default build (1024 blocks) can never go out of range, which is why this override is needed.

// File: rtl/wp_pkg.sv
// Package: shared types and the state-transition rule for the write-protection controller.
// Assumes: three protection states. The tight state is left only by reset.
package wp_pkg;

    typedef enum logic [1:0] {
        WP_UNLOCKED = 2'd0,
        WP_LOCKED   = 2'd1,
        WP_TIGHT    = 2'd2
    } wp_state_e;

    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_LOCK   = 2'd1,
        OP_UNLOCK = 2'd2,
        OP_TIGHT  = 2'd3
    } wp_op_e;

    localparam logic [1:0] RA_START  = 2'd0;
    localparam logic [1:0] RA_SELECT = 2'd1;
    localparam logic [1:0] RA_STATUS = 2'd2;
    localparam logic [1:0] RA_IRQ    = 2'd3;

    // Next state of one block under one command.
    function automatic wp_state_e wp_next(wp_state_e cur, wp_op_e op);
        wp_state_e nxt;
        nxt = cur;
        if (cur != WP_TIGHT) begin
            case (op)
                OP_LOCK:   nxt = WP_LOCKED;
                OP_UNLOCK: nxt = WP_UNLOCKED;
                OP_TIGHT:  nxt = (cur == WP_LOCKED) ? WP_TIGHT : cur;
                default:   nxt = cur;
            endcase
        end
        return nxt;
    endfunction

    // One-hot status code: bit2 unlocked, bit1 locked, bit0 tight.
    function automatic logic [2:0] wp_code(wp_state_e st);
        case (st)
            WP_UNLOCKED: return 3'b100;
            WP_TIGHT:    return 3'b001;
            default:     return 3'b010;
        endcase
    endfunction

endpackage

// File: rtl/wp_host_regs.sv
// Module: host-visible registers (start block, status select, reset-done flag, range error).
// Assumes: synchronous active-low reset. The out-of-range decision is made by the parent.
module wp_host_regs
    import wp_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic              int_auto,
    input  logic              cmd_oob,
    output logic [ADDR_W-1:0] start_blk,
    output logic [ADDR_W-1:0] sel_blk,
    output logic              armed,
    output logic              rst_irq,
    output logic              addr_err
);

    logic cmd_fire;
    logic irq_pend;
    logic unused_wdata;

    assign cmd_fire     = cmd_valid && (cmd_op != OP_NONE);
    assign unused_wdata = ^reg_wdata[DATA_W-1:ADDR_W];

    // Start-block register and the armed flag that gates commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_blk <= '0;
            armed     <= 1'b0;
        end else if (reg_wr && reg_addr == RA_START) begin
            start_blk <= reg_wdata[ADDR_W-1:0];
            armed     <= 1'b1;
        end
    end

    // Status-select register.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  sel_blk <= '0;
        else if (reg_wr && reg_addr == RA_SELECT)    sel_blk <= reg_wdata[ADDR_W-1:0];
    end

    // Reset-done flag: set once after reset, cleared by a write of 0 or by an auto-mode command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_pend <= 1'b1;
            rst_irq  <= 1'b0;
        end else begin
            irq_pend <= 1'b0;
            if (irq_pend)
                rst_irq <= 1'b1;
            else if ((reg_wr && reg_addr == RA_IRQ && !reg_wdata[0]) || (cmd_fire && int_auto))
                rst_irq <= 1'b0;
        end
    end

    // Sticky range error on an armed command that names no block.
    always_ff @(posedge clk) begin
        if (!rst_n)                          addr_err <= 1'b0;
        else if (cmd_fire && armed && cmd_oob) addr_err <= 1'b1;
    end

endmodule

// File: rtl/wp_state_array.sv
// Module: per-block protection state storage with one update port and two read ports.
// Assumes: read indices at or above NUM_BLOCKS are flagged through rd_ok_*.
module wp_state_array
    import wp_pkg::*;
#(
    parameter int NUM_BLOCKS = 1024,
    parameter int ADDR_W     = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [ADDR_W-1:0] upd_blk,
    input  logic [1:0]        upd_op,
    input  logic [ADDR_W-1:0] rd_blk_a,
    input  logic [ADDR_W-1:0] rd_blk_b,
    output wp_state_e         rd_state_a,
    output wp_state_e         rd_state_b,
    output logic              rd_ok_a,
    output logic              rd_ok_b
);

    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NUM_BLOCKS);

    wp_state_e st [NUM_BLOCKS];

    for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_blk
        // One block: reset to locked, apply the command when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                st[g] <= WP_LOCKED;
            else if (upd_en && upd_blk == ADDR_W'(g))
                st[g] <= wp_next(st[g], wp_op_e'(upd_op));
        end
    end

    assign rd_ok_a = {1'b0, rd_blk_a} < LIMIT;
    assign rd_ok_b = {1'b0, rd_blk_b} < LIMIT;

    // Guarded read ports.
    always_comb begin
        rd_state_a = rd_ok_a ? st[rd_blk_a] : WP_LOCKED;
        rd_state_b = rd_ok_b ? st[rd_blk_b] : WP_LOCKED;
    end

endmodule

// File: rtl/wp_ctrl.sv
// Module: top of the flash block write-protection controller.
// Assumes: synchronous host port, one-cycle command strobe, combinational read data.
module wp_ctrl
    import wp_pkg::*;
#(
    parameter int NUM_BLOCKS = 1024,
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic              int_auto,
    input  logic              otp_first_block,
    input  logic [ADDR_W-1:0] query_blk,
    output logic              query_wr_en,
    output logic              rst_irq,
    output logic              addr_err
);

    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NUM_BLOCKS);

    logic [ADDR_W-1:0] start_q;
    logic [ADDR_W-1:0] sel_q;
    logic              armed;
    logic              cmd_oob;
    logic              upd_en;
    wp_state_e         sel_state;
    wp_state_e         qry_state;
    logic              sel_ok;
    logic              qry_ok;
    logic [2:0]        stat_code;

    assign cmd_oob = {1'b0, start_q} >= LIMIT;
    assign upd_en  = cmd_valid && (cmd_op != OP_NONE) && armed && !cmd_oob;

    wp_host_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .int_auto  (int_auto),
        .cmd_oob   (cmd_oob),
        .start_blk (start_q),
        .sel_blk   (sel_q),
        .armed     (armed),
        .rst_irq   (rst_irq),
        .addr_err  (addr_err)
    );

    wp_state_array #(.NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W)) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_en     (upd_en),
        .upd_blk    (start_q),
        .upd_op     (cmd_op),
        .rd_blk_a   (sel_q),
        .rd_blk_b   (query_blk),
        .rd_state_a (sel_state),
        .rd_state_b (qry_state),
        .rd_ok_a    (sel_ok),
        .rd_ok_b    (qry_ok)
    );

    // Status code of the selected block, with the one-time-programmable override.
    always_comb begin
        if (!sel_ok)                               stat_code = 3'b000;
        else if (otp_first_block && sel_q == '0)   stat_code = 3'b010;
        else                                       stat_code = wp_code(sel_state);
    end

    // Write permission for the queried block.
    assign query_wr_en = qry_ok && !(otp_first_block && query_blk == '0)
                         && (qry_state == WP_UNLOCKED);

    // Read data mux.
    always_comb begin
        case (reg_addr)
            RA_START:  reg_rdata = {{(DATA_W-ADDR_W){1'b0}}, start_q};
            RA_SELECT: reg_rdata = {{(DATA_W-ADDR_W){1'b0}}, sel_q};
            RA_STATUS: reg_rdata = {{(DATA_W-3){1'b0}}, stat_code};
            default:   reg_rdata = {{(DATA_W-2){1'b0}}, addr_err, rst_irq};
        endcase
    end

endmodule

// File: rtl/wp_ctrl_chk.sv
// Module: property checker for wp_ctrl, attached by bind.
// Assumes: sel_blk is the top's internal status-select register.
module wp_ctrl_chk #(
    parameter int NUM_BLOCKS = 1024,
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        reg_addr,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              cmd_valid,
    input logic [1:0]        cmd_op,
    input logic              int_auto,
    input logic              otp_first_block,
    input logic [ADDR_W-1:0] query_blk,
    input logic              query_wr_en,
    input logic              rst_irq,
    input logic              addr_err,
    input logic [ADDR_W-1:0] sel_blk
);

    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NUM_BLOCKS);

    assert_start_reserved_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd0) |-> ((reg_rdata >> ADDR_W) == '0));

    assert_status_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd2 && {1'b0, sel_blk} < LIMIT)
        |-> ($countones(reg_rdata[2:0]) == 1 && (reg_rdata >> 3) == '0));

    assert_otp_no_wr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (otp_first_block && query_blk == '0) |-> !query_wr_en);

    assert_wr_en_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (query_wr_en && reg_addr == 2'd2 && query_blk == sel_blk) |-> reg_rdata[2]);

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |=> addr_err);

    assert_irq_auto_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_irq && cmd_valid && cmd_op != 2'd0 && int_auto) |=> !rst_irq);

endmodule

bind wp_ctrl wp_ctrl_chk #(.NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .reg_addr        (reg_addr),
    .reg_rdata       (reg_rdata),
    .cmd_valid       (cmd_valid),
    .cmd_op          (cmd_op),
    .int_auto        (int_auto),
    .otp_first_block (otp_first_block),
    .query_blk       (query_blk),
    .query_wr_en     (query_wr_en),
    .rst_irq         (rst_irq),
    .addr_err        (addr_err),
    .sel_blk         (sel_q)
);

// File: tb/wp_ctrl_tb_top.sv
module wp_ctrl_tb_top;

    localparam int NB = 1000;
    localparam int AW = 10;
    localparam int DW = 16;
    localparam int NV = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'd0;
    logic          int_auto = 1'b0;
    logic          otp_first_block = 1'b0;
    logic [AW-1:0] query_blk = '0;
    logic          query_wr_en;
    logic          rst_irq;
    logic          addr_err;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    wp_ctrl #(.NUM_BLOCKS(NB), .ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .int_auto(int_auto), .otp_first_block(otp_first_block),
        .query_blk(query_blk), .query_wr_en(query_wr_en), .rst_irq(rst_irq),
        .addr_err(addr_err)
    );

    // Vector: {opcode[1:0], block[9:0], expected status[2:0]}; opcodes 1 lock, 2 unlock, 3 tighten.
    localparam logic [14:0] VEC [NV] = '{
        {2'd2, 10'd5,   3'b100},  // R3 unlock
        {2'd1, 10'd5,   3'b010},  // R3 lock
        {2'd3, 10'd5,   3'b001},  // R5 tighten locked
        {2'd2, 10'd5,   3'b001},  // R5 unlock ignored
        {2'd1, 10'd5,   3'b001},  // R5 lock ignored
        {2'd2, 10'd7,   3'b100},  // R3 unlock
        {2'd3, 10'd7,   3'b100},  // R6 tighten on unlocked ignored
        {2'd2, 10'd999, 3'b100},  // R3 top block
        {2'd2, 10'd0,   3'b100},  // R3 block 0
        {2'd2, 10'd7,   3'b100},  // R3 repeat unlock
        {2'd1, 10'd7,   3'b010}   // R3 relock
    };

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic cmd(input logic [1:0] op);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'd0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [DW-1:0] d;
        do_reset();
        rd(2'd3, d); chk("R10 irq set after reset", d, 16'h0001);
        rd(2'd0, d); chk("R1 start reset value", d, 16'h0000);
        rd(2'd2, d); chk("R4 block0 locked", d, 16'h0002);
        wr(2'd1, 16'd999);
        rd(2'd2, d); chk("R4 block999 locked", d, 16'h0002);
        wr(2'd1, 16'd0);
        cmd(2'd2);
        rd(2'd2, d); chk("R2 command before start write ignored", d, 16'h0002);

        for (int i = 0; i < NV; i++) begin
            wr(2'd0, {6'd0, VEC[i][12:3]});
            cmd(VEC[i][14:13]);
            wr(2'd1, {6'd0, VEC[i][12:3]});
            rd(2'd2, d); chk($sformatf("R3 vector %0d status", i), d, {13'd0, VEC[i][2:0]});
            query_blk = VEC[i][12:3]; #1;
            chk($sformatf("R8 vector %0d write enable", i), {15'd0, query_wr_en},
                {15'd0, VEC[i][2:0] == 3'b100});
        end

        // Block 0 is unlocked here; OTP override.
        otp_first_block = 1'b1;
        wr(2'd1, 16'd0);
        rd(2'd2, d); chk("R7 otp block0 status", d, 16'h0002);
        query_blk = '0; #1;
        chk("R7 otp block0 write enable", {15'd0, query_wr_en}, 16'h0000);
        otp_first_block = 1'b0; #1;
        rd(2'd2, d); chk("R3 block0 unlocked without otp", d, 16'h0004);
        query_blk = 10'd5; #1;
        chk("R8 tight block not writable", {15'd0, query_wr_en}, 16'h0000);

        // Out-of-range start block.
        chk("R9 no error yet", {15'd0, addr_err}, 16'h0000);
        wr(2'd0, 16'hFFFF);
        rd(2'd0, d); chk("R1 reserved bits read zero", d, 16'h03FF);
        cmd(2'd2);
        rd(2'd3, d); chk("R9 error flag set", d, 16'h0003);
        wr(2'd0, 16'd999);
        cmd(2'd1);
        wr(2'd1, 16'd999);
        rd(2'd2, d); chk("R9 in-range command after error", d, 16'h0002);
        chk("R9 error sticky", {15'd0, addr_err}, 16'h0001);

        wr(2'd3, 16'h0000);
        rd(2'd3, d); chk("R10 write zero clears irq", d[0] ? 16'h1 : 16'h0, 16'h0000);

        do_reset();
        wr(2'd1, 16'd5);
        rd(2'd2, d); chk("R5 reset releases tight block", d, 16'h0002);
        chk("R9 reset clears error", {15'd0, addr_err}, 16'h0000);
        cmd(2'd1);
        chk("R10 command without auto keeps irq", {15'd0, rst_irq}, 16'h0001);
        int_auto = 1'b1;
        cmd(2'd1);
        chk("R10 auto command clears irq", {15'd0, rst_irq}, 16'h0000);
        int_auto = 1'b0;
        rd(2'd2, d); chk("R2 unarmed lock leaves block5 locked", d, 16'h0002);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule